// File: doc/BRIEF.md
# Byte/Word Load-Store Alignment Unit

This unit sits between the memory data register of a simple processor datapath and a byte-addressable memory that is two bytes wide. It holds the data register itself, formats what goes into it, formats what comes out of it onto the processor bus, and decodes the two byte-lane write strobes for the memory.

On a read, the data register captures the full memory word. The bus then sees one of two values. For a word access it sees the whole register. For a byte access it sees one byte of the register, picked by the lowest address bit and sign-extended to the full width. On a write, the data register captures the source operand. A word store takes the operand unchanged. A byte store copies the operand's low byte into every byte lane. The write strobes alone decide which lane the memory actually updates.

A word access to an odd address is not raised as an exception here. The unit drives no strobe for it and sets a misalignment flag, and the surrounding control decides what to do.

Top module: `lsalign_top`

## Requirements
- R1: A synchronous active-high reset clears the data register to 0x0000.
- R2: With size_i = 0 (byte), load_bus_o is the byte mdr_o[7:0] when lane_i = 0 or mdr_o[15:8] when lane_i = 1, with bits [15:8] of load_bus_o all equal to bit 7 of that byte. The output follows the inputs in the same cycle.
- R3: With size_i = 1 (word), load_bus_o equals mdr_o in the same cycle.
- R4: When mdr_ld_i = 1 and rw_i = 0 (read) at a rising edge, mdr_o shows mem_rdata_i after that edge. When mdr_ld_i = 0, mdr_o keeps its value.
- R5: When mdr_ld_i = 1, rw_i = 1 (write) and size_i = 1 at a rising edge, mdr_o shows src_i after that edge.
- R6: When mdr_ld_i = 1, rw_i = 1 and size_i = 0 at a rising edge, mdr_o shows {src_i[7:0], src_i[7:0]} after that edge.
- R7: we_o is 2'b00 whenever rw_i = 0 or mem_en_i = 0.
- R8: For a byte write with mem_en_i = 1, lane_i = 0 gives we_o = 2'b01 (bit 0 strobes bits [7:0]) and lane_i = 1 gives we_o = 2'b10 (bit 1 strobes bits [15:8]).
- R9: A word write with mem_en_i = 1 and lane_i = 0 gives we_o = 2'b11.
- R10: A word access (read or write) with mem_en_i = 1 and lane_i = 1 sets misalign_o = 1 and we_o = 2'b00. In every other case misalign_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mdr_ld_i | input | 1 | Load strobe for the data register |
| rw_i | input | 1 | 0 = read, 1 = write |
| size_i | input | 1 | 0 = byte, 1 = word |
| mem_en_i | input | 1 | A memory access is active this cycle |
| lane_i | input | 1 | Address bit 0 (byte lane) |
| mem_rdata_i | input | 16 | Word read from memory |
| src_i | input | 16 | Source register operand for stores |
| mdr_o | output | 16 | Data register contents |
| load_bus_o | output | 16 | Aligned load value for the processor bus |
| we_o | output | 2 | Byte-lane write strobes (bit 1 high lane, bit 0 low lane) |
| misalign_o | output | 1 | Word access at an odd address |

## Verification
The data register takes one clock. A value captured at a rising edge is due on mdr_o after that edge. The load bus, strobes and flag are combinational from the held inputs and the register, so they are due in the same cycle. The bench drives every vector at a falling edge with the load strobe set. It samples at the next falling edge, after exactly one rising edge. At that point the new register value and the combinational results for the still-held controls can be checked together. The hold and reset checks follow the same rule: they sample half a period after the edge that should have left the register unchanged or cleared it.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;

    localparam int DEF_WORD_W = 16;
    localparam int DEF_BYTE_W = 8;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } size_e;

    typedef struct packed {
        dir_e  dir;
        size_e size;
        logic  en;
    } access_t;

endpackage

// File: rtl/lsalign_load_fmt.sv
module lsalign_load_fmt
    import lsalign_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int LANES  = WORD_W / BYTE_W,
    parameter int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  lane_i,
    input  size_e             size_i,
    output logic [WORD_W-1:0] bus_o
);
    localparam int EXT_W = WORD_W - BYTE_W;

    logic [BYTE_W-1:0] lane_bytes [LANES];
    logic [BYTE_W-1:0] picked;
    logic [WORD_W-1:0] extended;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_bytes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign picked   = lane_bytes[lane_i];
    assign extended = {{EXT_W{picked[BYTE_W-1]}}, picked};

    always_comb begin
        if (size_i == SZ_WORD) bus_o = word_i;
        else                   bus_o = extended;
    end
endmodule

// File: rtl/lsalign_store_fmt.sv
module lsalign_store_fmt
    import lsalign_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int LANES  = WORD_W / BYTE_W
) (
    input  logic [WORD_W-1:0] src_i,
    input  size_e             size_i,
    output logic [WORD_W-1:0] data_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_o[g*BYTE_W +: BYTE_W] =
            (size_i == SZ_WORD) ? src_i[g*BYTE_W +: BYTE_W] : src_i[BYTE_W-1:0];
    end
endmodule

// File: rtl/lsalign_we_dec.sv
module lsalign_we_dec
    import lsalign_pkg::*;
#(
    parameter int LANES = DEF_WORD_W / DEF_BYTE_W,
    parameter int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  access_t          ctl_i,
    input  logic [IDX_W-1:0] lane_i,
    output logic [LANES-1:0] we_o,
    output logic             misalign_o
);
    always_comb begin
        we_o       = '0;
        misalign_o = 1'b0;
        if (ctl_i.en) begin
            if (ctl_i.size == SZ_WORD) begin
                if (lane_i != '0)             misalign_o = 1'b1;
                else if (ctl_i.dir == DIR_WR) we_o = '1;
            end else if (ctl_i.dir == DIR_WR) begin
                we_o[lane_i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsalign_mdr_reg.sv
module lsalign_mdr_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_i,
    input  logic [WORD_W-1:0] d_i,
    output logic [WORD_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (ld_i) q_o <= d_i;
    end
endmodule

// File: rtl/lsalign_top.sv
module lsalign_top
    import lsalign_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int LANES  = WORD_W / BYTE_W,
    parameter int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdr_ld_i,
    input  logic              rw_i,
    input  logic              size_i,
    input  logic              mem_en_i,
    input  logic [IDX_W-1:0]  lane_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic [WORD_W-1:0] src_i,
    output logic [WORD_W-1:0] mdr_o,
    output logic [WORD_W-1:0] load_bus_o,
    output logic [LANES-1:0]  we_o,
    output logic              misalign_o
);
    localparam int EXT_W = WORD_W - BYTE_W;

    access_t           ctl;
    logic [WORD_W-1:0] store_word;
    logic [WORD_W-1:0] mdr_next;

    assign ctl.dir  = dir_e'(rw_i);
    assign ctl.size = size_e'(size_i);
    assign ctl.en   = mem_en_i;

    lsalign_store_fmt #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LANES(LANES)) u_store (
        .src_i  (src_i),
        .size_i (ctl.size),
        .data_o (store_word)
    );

    assign mdr_next = (ctl.dir == DIR_WR) ? store_word : mem_rdata_i;

    lsalign_mdr_reg #(.WORD_W(WORD_W)) u_mdr (
        .clk  (clk),
        .rst  (rst),
        .ld_i (mdr_ld_i),
        .d_i  (mdr_next),
        .q_o  (mdr_o)
    );

    lsalign_load_fmt #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_load (
        .word_i (mdr_o),
        .lane_i (lane_i),
        .size_i (ctl.size),
        .bus_o  (load_bus_o)
    );

    lsalign_we_dec #(.LANES(LANES), .IDX_W(IDX_W)) u_we (
        .ctl_i      (ctl),
        .lane_i     (lane_i),
        .we_o       (we_o),
        .misalign_o (misalign_o)
    );

    // R2
    byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
        !size_i |-> load_bus_o[WORD_W-1:BYTE_W] == {EXT_W{load_bus_o[BYTE_W-1]}});

    // R3
    word_pass_chk: assert property (@(posedge clk) disable iff (rst)
        size_i |-> load_bus_o == mdr_o);

    // R4
    mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mdr_ld_i |=> $stable(mdr_o));

    // R4
    mdr_read_chk: assert property (@(posedge clk) disable iff (rst)
        (mdr_ld_i && !rw_i) |=> mdr_o == $past(mem_rdata_i));

    // R5
    word_store_chk: assert property (@(posedge clk) disable iff (rst)
        (mdr_ld_i && rw_i && size_i) |=> mdr_o == $past(src_i));

    // R6
    byte_store_chk: assert property (@(posedge clk) disable iff (rst)
        (mdr_ld_i && rw_i && !size_i) |=>
            (mdr_o[BYTE_W-1:0] == $past(src_i[BYTE_W-1:0])) &&
            (mdr_o[WORD_W-1:BYTE_W] == mdr_o[BYTE_W-1:0]));

    // R7
    we_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(rw_i && mem_en_i) |-> we_o == '0);

    // R8
    byte_we_chk: assert property (@(posedge clk) disable iff (rst)
        (rw_i && mem_en_i && !size_i) |-> ($countones(we_o) == 1) && we_o[lane_i]);

    // R9
    word_we_chk: assert property (@(posedge clk) disable iff (rst)
        (rw_i && mem_en_i && size_i && lane_i == '0) |-> we_o == '1);

    // R10
    misalign_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (we_o == '0) && size_i && mem_en_i && lane_i != '0);
endmodule

// File: tb/sim_lsalign_top.sv
module sim_lsalign_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [23:0] tag;
        logic        rw;
        logic        size;
        logic        lane;
        logic        en;
        logic [15:0] data;
        logic [15:0] exp_mdr;
        logic [15:0] exp_bus;
        logic [1:0]  exp_we;
        logic        exp_mis;
    } vec_t;

    // rw: 1 = write; size: 1 = word; we bit0 = low lane
    localparam vec_t VEC [NVEC] = '{
        '{"R2 ", 1'b0, 1'b0, 1'b0, 1'b1, 16'h12F4, 16'h12F4, 16'hFFF4, 2'b00, 1'b0},
        '{"R2 ", 1'b0, 1'b0, 1'b1, 1'b1, 16'h8A34, 16'h8A34, 16'hFF8A, 2'b00, 1'b0},
        '{"R2 ", 1'b0, 1'b0, 1'b1, 1'b1, 16'h7F80, 16'h7F80, 16'h007F, 2'b00, 1'b0},
        '{"R2 ", 1'b0, 1'b0, 1'b0, 1'b1, 16'h7F80, 16'h7F80, 16'hFF80, 2'b00, 1'b0},
        '{"R3 ", 1'b0, 1'b1, 1'b0, 1'b1, 16'hBEEF, 16'hBEEF, 16'hBEEF, 2'b00, 1'b0},
        '{"R10", 1'b0, 1'b1, 1'b1, 1'b1, 16'h1234, 16'h1234, 16'h1234, 2'b00, 1'b1},
        '{"R9 ", 1'b1, 1'b1, 1'b0, 1'b1, 16'hA55A, 16'hA55A, 16'hA55A, 2'b11, 1'b0},
        '{"R8 ", 1'b1, 1'b0, 1'b0, 1'b1, 16'h12C3, 16'hC3C3, 16'hFFC3, 2'b01, 1'b0},
        '{"R6 ", 1'b1, 1'b0, 1'b1, 1'b1, 16'h3456, 16'h5656, 16'h0056, 2'b10, 1'b0},
        '{"R10", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F, 16'h0F0F, 16'h0F0F, 2'b00, 1'b1},
        '{"R7 ", 1'b1, 1'b0, 1'b1, 1'b0, 16'h0077, 16'h7777, 16'h0077, 2'b00, 1'b0},
        '{"R7 ", 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 2'b00, 1'b0},
        '{"R7 ", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001, 16'h0001, 16'h0001, 2'b00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdr_ld = 1'b0;
    logic        rw = 1'b0;
    logic        size = 1'b1;
    logic        mem_en = 1'b0;
    logic [0:0]  lane = 1'b0;
    logic [15:0] rdata = '0;
    logic [15:0] src = '0;
    logic [15:0] mdr, bus;
    logic [1:0]  we;
    logic        mis;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsalign_top u0 (
        .clk(clk), .rst(rst), .mdr_ld_i(mdr_ld), .rw_i(rw), .size_i(size),
        .mem_en_i(mem_en), .lane_i(lane), .mem_rdata_i(rdata), .src_i(src),
        .mdr_o(mdr), .load_bus_o(bus), .we_o(we), .misalign_o(mis)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset value, word view of it
        chk("R1", "mdr after reset", mdr, 16'h0000);
        chk("R1", "bus after reset", bus, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            rw = VEC[i].rw; size = VEC[i].size; lane = VEC[i].lane;
            mem_en = VEC[i].en; rdata = VEC[i].data; src = VEC[i].data;
            mdr_ld = 1'b1;
            @(negedge clk);
            chk(string'(VEC[i].tag), "mdr", mdr, VEC[i].exp_mdr);
            chk(string'(VEC[i].tag), "bus", bus, VEC[i].exp_bus);
            chk(string'(VEC[i].tag), "we", {14'd0, we}, {14'd0, VEC[i].exp_we});
            chk(string'(VEC[i].tag), "misalign", {15'd0, mis}, {15'd0, VEC[i].exp_mis});
        end

        // R4: read loads memory word, not the source operand
        rw = 1'b0; size = 1'b1; lane = 1'b0; mem_en = 1'b1;
        rdata = 16'h1111; src = 16'h2222; mdr_ld = 1'b1;
        @(negedge clk);
        chk("R4", "read capture", mdr, 16'h1111);

        // R4: no strobe, register holds while inputs move
        mdr_ld = 1'b0; rdata = 16'h9999; rw = 1'b1;
        @(negedge clk);
        chk("R4", "hold", mdr, 16'h1111);

        // R5: word store takes the source operand, not memory data
        mdr_ld = 1'b1; rw = 1'b1; size = 1'b1; src = 16'h2222;
        @(negedge clk);
        chk("R5", "word store", mdr, 16'h2222);

        // R2: byte view of high lane with bit 7 clear
        mdr_ld = 1'b0; rw = 1'b0; size = 1'b0; lane = 1'b1;
        @(negedge clk);
        chk("R2", "high lane positive", bus, 16'h0022);

        // R1: reset mid-run clears the register
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; size = 1'b1;
        @(negedge clk);
        chk("R1", "mid-run reset", mdr, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule